// File: doc/BRIEF.md
# Multi-Word Block Load Sequencer

This block carries out one block-load command at a time. A command gives a base address, an offset, a byte count and a destination register index. The block adds base and offset to get a byte address. It reads the covering 32-bit words from local memory through a request/grant port. Each returned word goes into the destination register bank through a byte-enabled write port. Bytes keep the lane they had in memory, so an unaligned start leaves the leading lanes of the first destination word untouched.

The memory answers one clock after a granted request. The first word is therefore written in the third clock after the command is accepted. Later words follow one per clock. Every clock in which the arbiter withholds the grant adds one clock to the load. `busy_o` covers the whole load, and `done_o` pulses once when the load has finished.

Top module: `blk_load_seq`

## Requirements
- R1: With no stall, the first destination write strobe is high in the third clock after the clock edge that accepted the command.
- R2: A load makes exactly n = ceil((a + count) / 4) write strobes in consecutive clocks, where a is the low two bits of the start address. Without stalls the load takes 3 + (n - 1) clocks, so a 16-byte aligned load takes 6 clocks.
- R3: The start address is (base + offset) mod 2^AW. Beat i requests word address (start >> 2) + i, and the word returned one clock after a granted request is the data for that beat.
- R4: The memory byte at start + j is written to lane (a + j) mod 4 of bank word (dst + (a + j) / 4) mod NREG, with byte enable bit k selecting bits 8k+7..8k. Lanes outside the requested bytes get no enable.
- R5: A clock with the request high and the grant low adds one clock to the load and holds the requested word address.
- R6: `busy_o` is high from the clock after acceptance through the clock of the last write strobe, which is n + 2 + s clocks for s stall clocks.
- R7: `done_o` is high for exactly one clock, the clock after the last write strobe, and `busy_o` is low in that clock.
- R8: A command presented while `busy_o` is high is ignored.
- R9: A command with a byte count of zero is ignored. Counts from 1 to 124 are supported.
- R10: During and after reset, `busy_o`, `done_o`, `mem_req_o` and `dst_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present, taken when idle |
| cmd_base_i | input | AW | Base byte address |
| cmd_offset_i | input | AW | Byte offset added to base |
| cmd_count_i | input | CW | Byte count, 1 to 124 |
| cmd_dst_i | input | $clog2(NREG) | First destination bank word |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-clock end-of-load pulse |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | AW-2 | Word address |
| mem_gnt_i | input | 1 | Arbiter grant for this clock |
| mem_rdata_i | input | 32 | Read word, one clock after grant |
| dst_we_o | output | 1 | Bank write strobe |
| dst_idx_o | output | $clog2(NREG) | Bank word index |
| dst_be_o | output | 4 | Bank byte-lane enables |
| dst_data_o | output | 32 | Bank write data |

## Verification
The bench builds the block with AW = 10, CW = 7 and NREG = 32. The narrow address lets base plus offset wrap past the top of memory with small operands. The 32-word bank lets a 124-byte load from lane 3 cover every bank word and wrap the destination index. Stalls are placed both before the first grant and in the middle of a stream, so the first-word latency and the held word index are both exercised.

// File: rtl/blk_load_pkg.sv
package blk_load_pkg;
  localparam int unsigned BEAT_BYTES = 4;

  typedef struct packed {
    logic [BEAT_BYTES-1:0] be;
    logic                  last;
  } beat_tag_t;

  // lanes from start lane upward
  function automatic logic [3:0] head_mask(input logic [1:0] lane);
    return 4'b1111 << lane;
  endfunction

  // lanes up to and including end lane
  function automatic logic [3:0] tail_mask(input logic [1:0] lane);
    return 4'b1111 >> (2'd3 - lane);
  endfunction
endpackage

// File: rtl/blk_issue.sv
module blk_issue
  import blk_load_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 7,
  parameter int unsigned RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [AW-1:0] cmd_base_i,
  input  logic [AW-1:0] cmd_offset_i,
  input  logic [CW-1:0] cmd_count_i,
  input  logic [RW-1:0] cmd_dst_i,
  input  logic          busy_i,
  output logic          active_o,
  output logic          mem_req_o,
  output logic [AW-3:0] mem_addr_o,
  input  logic          mem_gnt_i,
  output logic          beat_v_o,
  output beat_tag_t     beat_tag_o,
  output logic [RW-1:0] beat_reg_o
);
  localparam int unsigned WAW = AW - 2;
  localparam int unsigned TW  = CW + 1;
  localparam int unsigned WCW = CW - 1;

  logic           active_q;
  logic [WCW-1:0] idx_q, nw_q;
  logic [WAW-1:0] waddr_q;
  logic [1:0]     lane_q, end_lane_q;
  logic [RW-1:0]  dbase_q;

  logic           accept, fire, is_last;
  logic [AW-1:0]  start;
  logic [TW-1:0]  total;
  logic [WCW-1:0] nw_d;
  logic [1:0]     end_lane_d;

  assign accept     = cmd_valid_i && !busy_i && (cmd_count_i != '0);
  assign start      = cmd_base_i + cmd_offset_i;
  assign total      = TW'(cmd_count_i) + TW'(start[1:0]);
  assign nw_d       = WCW'((total + TW'(3)) >> 2);
  assign end_lane_d = start[1:0] + cmd_count_i[1:0] + 2'd3;

  assign is_last = (idx_q == nw_q - WCW'(1));
  assign fire    = active_q && mem_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      idx_q      <= '0;
      nw_q       <= '0;
      waddr_q    <= '0;
      lane_q     <= '0;
      end_lane_q <= '0;
      dbase_q    <= '0;
    end else if (accept) begin
      active_q   <= 1'b1;
      idx_q      <= '0;
      nw_q       <= nw_d;
      waddr_q    <= start[AW-1:2];
      lane_q     <= start[1:0];
      end_lane_q <= end_lane_d;
      dbase_q    <= cmd_dst_i;
    end else if (fire) begin
      if (is_last) active_q <= 1'b0;
      else         idx_q    <= idx_q + WCW'(1);
    end
  end

  always_comb begin
    beat_tag_o.be = 4'b1111;
    if (idx_q == '0) beat_tag_o.be = beat_tag_o.be & head_mask(lane_q);
    if (is_last)     beat_tag_o.be = beat_tag_o.be & tail_mask(end_lane_q);
    beat_tag_o.last = is_last;
  end

  assign active_o   = active_q;
  assign mem_req_o  = active_q;
  assign mem_addr_o = waddr_q + WAW'(idx_q);
  assign beat_v_o   = fire;
  assign beat_reg_o = dbase_q + RW'(idx_q);
endmodule

// File: rtl/blk_beat_pipe.sv
module blk_beat_pipe
  import blk_load_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_v_i,
  input  beat_tag_t     beat_tag_i,
  input  logic [RW-1:0] beat_reg_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          pipe_busy_o,
  output logic          dst_we_o,
  output logic [RW-1:0] dst_idx_o,
  output logic [3:0]    dst_be_o,
  output logic [31:0]   dst_data_o,
  output logic          done_o
);
  // stage 1: memory read in flight; stage 2: bank write
  logic          s1_v, s2_v, done_q;
  beat_tag_t     s1_tag, s2_tag;
  logic [RW-1:0] s1_reg, s2_reg;
  logic [31:0]   s2_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s2_v    <= 1'b0;
      done_q  <= 1'b0;
      s1_tag  <= '0;
      s2_tag  <= '0;
      s1_reg  <= '0;
      s2_reg  <= '0;
      s2_data <= '0;
    end else begin
      s1_v   <= beat_v_i;
      s2_v   <= s1_v;
      done_q <= s2_v && s2_tag.last;
      if (beat_v_i) begin
        s1_tag <= beat_tag_i;
        s1_reg <= beat_reg_i;
      end
      if (s1_v) begin
        s2_tag  <= s1_tag;
        s2_reg  <= s1_reg;
        s2_data <= mem_rdata_i;
      end
    end
  end

  assign pipe_busy_o = s1_v || s2_v;
  assign dst_we_o    = s2_v;
  assign dst_idx_o   = s2_reg;
  assign dst_be_o    = s2_tag.be;
  assign dst_data_o  = s2_data;
  assign done_o      = done_q;
endmodule

// File: rtl/blk_load_seq.sv
module blk_load_seq
  import blk_load_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned CW   = 7,
  parameter int unsigned NREG = 32,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [AW-1:0] cmd_base_i,
  input  logic [AW-1:0] cmd_offset_i,
  input  logic [CW-1:0] cmd_count_i,
  input  logic [RW-1:0] cmd_dst_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic [AW-3:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          dst_we_o,
  output logic [RW-1:0] dst_idx_o,
  output logic [3:0]    dst_be_o,
  output logic [31:0]   dst_data_o
);
  logic          active, pipe_busy, beat_v;
  beat_tag_t     beat_tag;
  logic [RW-1:0] beat_reg;

  assign busy_o = active || pipe_busy;

  blk_issue #(.AW(AW), .CW(CW), .RW(RW)) i_issue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_base_i   (cmd_base_i),
    .cmd_offset_i (cmd_offset_i),
    .cmd_count_i  (cmd_count_i),
    .cmd_dst_i    (cmd_dst_i),
    .busy_i       (busy_o),
    .active_o     (active),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .beat_v_o     (beat_v),
    .beat_tag_o   (beat_tag),
    .beat_reg_o   (beat_reg)
  );

  blk_beat_pipe #(.RW(RW)) i_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beat_v_i    (beat_v),
    .beat_tag_i  (beat_tag),
    .beat_reg_i  (beat_reg),
    .mem_rdata_i (mem_rdata_i),
    .pipe_busy_o (pipe_busy),
    .dst_we_o    (dst_we_o),
    .dst_idx_o   (dst_idx_o),
    .dst_be_o    (dst_be_o),
    .dst_data_o  (dst_data_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/blk_load_seq_chk.sv
module blk_load_seq_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [CW-1:0] cmd_count_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic [AW-3:0] mem_addr_o,
  input logic          mem_gnt_i,
  input logic          dst_we_o
);
  // R6
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_count_i != '0) |=> busy_o);

  // R1
  first_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_count_i != '0) |=> !dst_we_o ##1 !dst_we_o);

  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R6
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_we_o |-> busy_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_count_i == '0) |=> !busy_o);
endmodule

bind blk_load_seq blk_load_seq_chk #(.AW(AW), .CW(CW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_count_i (cmd_count_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_gnt_i   (mem_gnt_i),
  .dst_we_o    (dst_we_o)
);

// File: tb/test_blk_load_seq.sv
module test_blk_load_seq;
  localparam int AW = 10;
  localparam int CW = 7;
  localparam int NREG = 32;
  localparam int RW = $clog2(NREG);
  localparam int NB = NREG * 4;
  localparam int MEMB = 1 << AW;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] off;
    logic [CW-1:0] cnt;
    logic [RW-1:0] dst;
    logic [3:0]    sfrom;
    logic [3:0]    sn;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{10'h040, 10'h000, 7'd16,  5'd0,  4'd0, 4'd0},
    '{10'h100, 10'h004, 7'd4,   5'd3,  4'd0, 4'd0},
    '{10'h021, 10'h000, 7'd1,   5'd5,  4'd0, 4'd0},
    '{10'h010, 10'h003, 7'd8,   5'd10, 4'd0, 4'd0},
    '{10'h200, 10'h020, 7'd124, 5'd0,  4'd0, 4'd0},
    '{10'h3F8, 10'h010, 7'd20,  5'd28, 4'd0, 4'd0},
    '{10'h080, 10'h000, 7'd16,  5'd2,  4'd1, 4'd3},
    '{10'h0C2, 10'h000, 7'd30,  5'd7,  4'd3, 4'd1},
    '{10'h001, 10'h002, 7'd123, 5'd1,  4'd5, 4'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_base = '0, cmd_off = '0;
  logic [CW-1:0] cmd_cnt = '0;
  logic [RW-1:0] cmd_dst = '0;
  logic          busy, done, mem_req, mem_gnt = 1'b1, dst_we;
  logic [AW-3:0] mem_addr;
  logic [31:0]   mem_rdata = '0, dst_data;
  logic [RW-1:0] dst_idx;
  logic [3:0]    dst_be;

  int checks = 0;
  int failures = 0;
  logic [7:0] bank [NB];

  always #2 clk = ~clk;

  blk_load_seq #(.AW(AW), .CW(CW), .NREG(NREG)) i_blk_load_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_base_i(cmd_base),
    .cmd_offset_i(cmd_off), .cmd_count_i(cmd_cnt), .cmd_dst_i(cmd_dst),
    .busy_o(busy), .done_o(done), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata), .dst_we_o(dst_we),
    .dst_idx_o(dst_idx), .dst_be_o(dst_be), .dst_data_o(dst_data)
  );

  function automatic logic [7:0] byte_val(input int b);
    logic [AW-1:0] a;
    a = AW'(b);
    return (a[7:0] + {a[9:8], 6'b0}) ^ 8'hA5;
  endfunction

  // synchronous memory, one clock read latency
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] <= byte_val(int'(mem_addr) * 4 + k);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic bank_init();
    for (int i = 0; i < NB; i++) bank[i] = 8'hE0 ^ 8'(i);
  endtask

  task automatic bank_apply();
    if (dst_we)
      for (int l = 0; l < 4; l++)
        if (dst_be[l]) bank[int'(dst_idx) * 4 + l] = dst_data[8*l +: 8];
  endtask

  task automatic run_vec(input vec_t v, input int inj);
    logic [7:0] expb [NB];
    int start, lane, n, s, busy_cnt, last_busy, wr_cnt, first_we, done_cnt, done_at, bad, bad_i;
    start = (int'(v.base) + int'(v.off)) % MEMB;
    lane = start % 4;
    n = (lane + int'(v.cnt) + 3) / 4;
    s = int'(v.sn);
    bank_init();
    for (int i = 0; i < NB; i++) expb[i] = bank[i];
    for (int j = 0; j < int'(v.cnt); j++)
      expb[(int'(v.dst) * 4 + lane + j) % NB] = byte_val((start + j) % MEMB);
    busy_cnt = 0; last_busy = 0; wr_cnt = 0; first_we = 0; done_cnt = 0; done_at = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_base = v.base; cmd_off = v.off; cmd_cnt = v.cnt; cmd_dst = v.dst;
    for (int c = 1; c <= n + s + 6; c++) begin
      @(negedge clk);
      if (c == inj && inj != 0) begin
        cmd_valid = 1'b1; cmd_base = 10'h300; cmd_off = '0; cmd_cnt = 7'd8;
        cmd_dst = v.dst + RW'(16);
      end else begin
        cmd_valid = 1'b0;
      end
      mem_gnt = !(s != 0 && c >= int'(v.sfrom) && c < int'(v.sfrom) + s);
      if (busy) begin busy_cnt++; last_busy = c; end
      if (dst_we) begin wr_cnt++; if (first_we == 0) first_we = c; end
      if (done) begin done_cnt++; done_at = c; end
      bank_apply();
    end
    mem_gnt = 1'b1;
    // R1: first write in clock 3, later only if stalled before first grant
    chk(first_we == ((v.sfrom == 4'd1) ? 3 + s : 3), "R1 first write clock", first_we,
        (v.sfrom == 4'd1) ? 3 + s : 3);
    // R2: one write per word
    chk(wr_cnt == n, "R2 write count", wr_cnt, n);
    // R5 R6: busy length including stall clocks
    chk(busy_cnt == n + 2 + s && last_busy == n + 2 + s, "R6 R5 busy length", busy_cnt, n + 2 + s);
    // R7: single done pulse after last write
    chk(done_cnt == 1 && done_at == n + 3 + s, "R7 done pulse clock", done_at, n + 3 + s);
    bad = 0; bad_i = 0;
    for (int i = 0; i < NB; i++) if (bank[i] !== expb[i]) begin
      if (bad == 0) bad_i = i;
      bad++;
    end
    // R3 R4: addressing and lane placement (R8 when a command was injected)
    chk(bad == 0, inj != 0 ? "R8 R3 R4 bank contents" : "R3 R4 bank contents",
        int'(bank[bad_i]), int'(expb[bad_i]));
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bank_init();
    repeat (3) @(negedge clk);
    // R10: outputs low in reset
    chk(!busy && !done && !mem_req && !dst_we, "R10 in reset", int'({busy, done, mem_req, dst_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !dst_we, "R10 after reset", int'({busy, done, mem_req, dst_we}), 0);

    for (int v = 0; v < NV; v++) run_vec(VECS[v], 0);

    // R8: second command while busy
    run_vec('{10'h050, 10'h000, 7'd24, 5'd4, 4'd0, 4'd0}, 2);

    // R9: zero count ignored
    begin
      int zb, zw;
      zb = 0; zw = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_base = 10'h020; cmd_off = '0; cmd_cnt = '0; cmd_dst = 5'd1;
      for (int c = 1; c <= 6; c++) begin
        @(negedge clk);
        cmd_valid = 1'b0;
        if (busy || mem_req) zb++;
        if (dst_we || done) zw++;
      end
      chk(zb == 0, "R9 zero count busy", zb, 0);
      chk(zw == 0, "R9 zero count writes", zw, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule